// File: doc/BRIEF.md
# SPI Status Flag and Service Request Router

This block sits beside the shift engine and the two FIFOs of an SPI peripheral. It turns one-cycle event pulses into sticky status flags, which software clears by writing 1 to a flag bit. It also presents three level indicators: transmit space available, receive data waiting, and shifter running.

Every event flag has its own enable bit. The interrupt line is the OR of every enabled flag that is routed to interrupt. The transmit-space request and the receive-data request each have a route select. When the select is set, that request drives its own DMA request line and no longer feeds the interrupt.

The block also enforces the receive overflow policy. When a word arrives at a full receive FIFO, the block either drops the word or tells the FIFO to replace stored data with it. In both cases it raises the overflow flag. The FIFO storage and the shifter are outside this block.

Top module: `spi_evt_router`

## Requirements
- R1: After reset, `flags` reads 0, `irq` is 0, and both DMA request outputs are 0.
- R2: The sticky flags are bit 0 (transfer done), bit 1 (queue end), bit 2 (transmit underflow) and bit 3 (receive overflow). Each one is set on the clock edge after its event. It then stays set until a write with `clr_we` high and a 1 in that bit of `clr_mask`. A 0 in the mask leaves the flag unchanged.
- R3: If an event and a write-1 clear hit the same sticky flag in the same cycle, the flag stays set.
- R4: The level flags are registered one cycle after their inputs. Bit 4 equals NOT `tx_full`, bit 5 equals NOT `rx_empty`, and bit 6 equals `shift_busy`. A write-1 clear has no effect on these three bits.
- R5: A word that arrives (`rx_word_in`) while `rx_full` is high and `cfg_rx_overwrite` is 0 gives `rx_push`=0 in that cycle, and the overflow flag is set.
- R6: A word that arrives while `rx_full` is high and `cfg_rx_overwrite` is 1 gives `rx_push`=1 and `rx_replace`=1 in that cycle, and the overflow flag is still set. A word that arrives while the FIFO is not full gives `rx_push`=1 and `rx_replace`=0.
- R7: `irq` is registered together with the flags. It is high exactly when some flag in bits 0..5 is set, its bit in `cfg_en` is set, and that flag is not routed to DMA.
- R8: When `cfg_dma_sel[0]` is 1, flag bit 4 AND `cfg_en[4]` drives `tx_dma_req` and is removed from `irq`. When `cfg_dma_sel[1]` is 1, flag bit 5 AND `cfg_en[5]` drives `rx_dma_req` in the same way.
- R9: A DMA request falls on the clock edge after its FIFO condition clears. That is one cycle after `tx_full` rises, or one cycle after `rx_empty` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ev_xfer_done | input | 1 | Frame completed pulse |
| ev_queue_end | input | 1 | Last queued frame completed pulse |
| ev_tx_underflow | input | 1 | Transmit FIFO underflow pulse |
| rx_word_in | input | 1 | Received word ready to enter the receive FIFO |
| tx_full | input | 1 | Transmit FIFO full |
| rx_full | input | 1 | Receive FIFO full |
| rx_empty | input | 1 | Receive FIFO empty |
| shift_busy | input | 1 | Shifter running |
| cfg_rx_overwrite | input | 1 | 1: an incoming word replaces stored data on overflow |
| cfg_en | input | 6 | Per-flag request enables for bits 0..5 |
| cfg_dma_sel | input | 2 | Route select: bit 0 for transmit space, bit 1 for receive data |
| clr_we | input | 1 | Clear strobe |
| clr_mask | input | 7 | Write-1-to-clear mask |
| flags | output | 7 | Status flags |
| irq | output | 1 | Interrupt request |
| tx_dma_req | output | 1 | Transmit DMA request |
| rx_dma_req | output | 1 | Receive DMA request |
| rx_push | output | 1 | Write strobe to the receive FIFO |
| rx_replace | output | 1 | The receive FIFO write replaces stored data |

## Verification
Two things can land on the same edge: a software clear and a hardware event on one sticky flag. The bench drives an event pulse together with a clear of the same bit. It then reads the flag one cycle later and expects it still set. A second clear with no event must then bring it to 0.

A receive overflow can also coincide with a clear of the overflow flag. The bench provokes this and judges `rx_push` and `rx_replace` within the arrival cycle, and the flag on the next edge.

// File: rtl/spi_evt_pkg.sv
package spi_evt_pkg;
    localparam int NFLAG   = 7;
    localparam int NEVT    = 6;
    localparam int F_DONE  = 0;
    localparam int F_QEND  = 1;
    localparam int F_TXUF  = 2;
    localparam int F_RXOF  = 3;
    localparam int F_FILL  = 4;
    localparam int F_DRAIN = 5;
    localparam int F_RUN   = 6;
    localparam logic [NFLAG-1:0] STICKY_MASK = 7'b000_1111;

    typedef struct packed {
        logic [NFLAG-1:0] flags;
        logic             irq;
        logic             tx_dma;
        logic             rx_dma;
    } evt_state_t;
endpackage

// File: rtl/spi_evt_flag_bank.sv
module spi_evt_flag_bank #(
    parameter int                N      = 7,
    parameter logic [N-1:0]      STICKY = '0
) (
    input  logic [N-1:0] cur,
    input  logic [N-1:0] set,
    input  logic         clr_we,
    input  logic [N-1:0] clr_mask,
    output logic [N-1:0] nxt
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        if (STICKY[i]) begin : g_sticky
            // set has priority over a same-cycle clear
            assign nxt[i] = set[i] | (cur[i] & ~(clr_we & clr_mask[i]));
        end else begin : g_level
            assign nxt[i] = set[i];
        end
    end
endmodule

// File: rtl/spi_evt_rx_policy.sv
module spi_evt_rx_policy (
    input  logic word_in,
    input  logic full,
    input  logic overwrite,
    output logic push,
    output logic replace,
    output logic overflow
);
    always_comb begin
        overflow = word_in & full;
        push     = word_in & (~full | overwrite);
        replace  = word_in & full & overwrite;
    end
endmodule

// File: rtl/spi_evt_req_route.sv
module spi_evt_req_route #(
    parameter int NE = 6,
    parameter int IF = 4,
    parameter int ID = 5
) (
    input  logic [NE-1:0] flags,
    input  logic [NE-1:0] en,
    input  logic [1:0]    dma_sel,
    output logic          irq,
    output logic          tx_dma,
    output logic          rx_dma
);
    logic [NE-1:0] to_dma;
    logic [NE-1:0] active;

    always_comb begin
        to_dma     = '0;
        to_dma[IF] = dma_sel[0];
        to_dma[ID] = dma_sel[1];
        active     = flags & en;
        irq        = |(active & ~to_dma);
        tx_dma     = active[IF] & dma_sel[0];
        rx_dma     = active[ID] & dma_sel[1];
    end
endmodule

// File: rtl/spi_evt_router.sv
module spi_evt_router
    import spi_evt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ev_xfer_done,
    input  logic             ev_queue_end,
    input  logic             ev_tx_underflow,
    input  logic             rx_word_in,
    input  logic             tx_full,
    input  logic             rx_full,
    input  logic             rx_empty,
    input  logic             shift_busy,
    input  logic             cfg_rx_overwrite,
    input  logic [NEVT-1:0]  cfg_en,
    input  logic [1:0]       cfg_dma_sel,
    input  logic             clr_we,
    input  logic [NFLAG-1:0] clr_mask,
    output logic [NFLAG-1:0] flags,
    output logic             irq,
    output logic             tx_dma_req,
    output logic             rx_dma_req,
    output logic             rx_push,
    output logic             rx_replace
);
    evt_state_t       st_d, st_q;
    logic [NFLAG-1:0] set_vec;
    logic [NFLAG-1:0] flags_nxt;
    logic             ovf;
    logic             irq_nxt, txd_nxt, rxd_nxt;

    spi_evt_rx_policy u_pol (
        .word_in   (rx_word_in),
        .full      (rx_full),
        .overwrite (cfg_rx_overwrite),
        .push      (rx_push),
        .replace   (rx_replace),
        .overflow  (ovf)
    );

    always_comb begin
        set_vec          = '0;
        set_vec[F_DONE]  = ev_xfer_done;
        set_vec[F_QEND]  = ev_queue_end;
        set_vec[F_TXUF]  = ev_tx_underflow;
        set_vec[F_RXOF]  = ovf;
        set_vec[F_FILL]  = ~tx_full;
        set_vec[F_DRAIN] = ~rx_empty;
        set_vec[F_RUN]   = shift_busy;
    end

    spi_evt_flag_bank #(.N(NFLAG), .STICKY(STICKY_MASK)) u_bank (
        .cur      (st_q.flags),
        .set      (set_vec),
        .clr_we   (clr_we),
        .clr_mask (clr_mask),
        .nxt      (flags_nxt)
    );

    spi_evt_req_route #(.NE(NEVT), .IF(F_FILL), .ID(F_DRAIN)) u_route (
        .flags   (flags_nxt[NEVT-1:0]),
        .en      (cfg_en),
        .dma_sel (cfg_dma_sel),
        .irq     (irq_nxt),
        .tx_dma  (txd_nxt),
        .rx_dma  (rxd_nxt)
    );

    always_comb begin
        st_d        = st_q;
        st_d.flags  = flags_nxt;
        st_d.irq    = irq_nxt;
        st_d.tx_dma = txd_nxt;
        st_d.rx_dma = rxd_nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flags      = st_q.flags;
    assign irq        = st_q.irq;
    assign tx_dma_req = st_q.tx_dma;
    assign rx_dma_req = st_q.rx_dma;
endmodule

// File: rtl/spi_evt_router_chk.sv
module spi_evt_router_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       ev_xfer_done,
    input logic       rx_word_in,
    input logic       rx_full,
    input logic       tx_full,
    input logic       cfg_rx_overwrite,
    input logic [5:0] cfg_en,
    input logic [1:0] cfg_dma_sel,
    input logic       clr_we,
    input logic [6:0] clr_mask,
    input logic [6:0] flags,
    input logic       irq,
    input logic       tx_dma_req,
    input logic       rx_push,
    input logic       rx_replace
);
    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (flags[0] && !(clr_we && clr_mask[0])) |=> flags[0]);
    p_event_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ev_xfer_done |=> flags[0]);
    p_fill_level_r4: assert property (@(posedge clk) disable iff (!rst_n)
        tx_full |=> !flags[4]);
    p_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_word_in && rx_full && !cfg_rx_overwrite) |-> !rx_push);
    p_ovf_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_word_in && rx_full) |=> flags[3]);
    p_overwrite_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_word_in && rx_full && cfg_rx_overwrite) |-> (rx_push && rx_replace));
    p_irq_src_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> |(flags[5:0] & cfg_en));
    p_tx_dma_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        tx_full |=> !tx_dma_req);
endmodule

bind spi_evt_router spi_evt_router_chk u_chk (
    .clk(clk), .rst_n(rst_n), .ev_xfer_done(ev_xfer_done),
    .rx_word_in(rx_word_in), .rx_full(rx_full), .tx_full(tx_full),
    .cfg_rx_overwrite(cfg_rx_overwrite), .cfg_en(cfg_en),
    .cfg_dma_sel(cfg_dma_sel), .clr_we(clr_we), .clr_mask(clr_mask),
    .flags(flags), .irq(irq), .tx_dma_req(tx_dma_req),
    .rx_push(rx_push), .rx_replace(rx_replace)
);

// File: tb/tb_spi_evt_router.sv
`timescale 1ns/1ps
module tb_spi_evt_router;
    logic       clk = 0;
    logic       rst_n = 0;
    logic       ev_xfer_done = 0, ev_queue_end = 0, ev_tx_underflow = 0;
    logic       rx_word_in = 0, tx_full = 1, rx_full = 0, rx_empty = 1;
    logic       shift_busy = 0, cfg_rx_overwrite = 0;
    logic [5:0] cfg_en = '0;
    logic [1:0] cfg_dma_sel = '0;
    logic       clr_we = 0;
    logic [6:0] clr_mask = '0;
    logic [6:0] flags;
    logic       irq, tx_dma_req, rx_dma_req, rx_push, rx_replace;

    int n_run = 0, n_fail = 0;
    bit done = 0;

    always #4 clk = ~clk;

    spi_evt_router dut (.*);

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic clear(logic [6:0] m);
        clr_we = 1; clr_mask = m; step(); clr_we = 0; clr_mask = '0;
    endtask

    task automatic t_reset();
        check("R1 flags", {25'b0, flags}, 0);
        check("R1 irq/dma", {29'b0, irq, tx_dma_req, rx_dma_req}, 0);
    endtask

    task automatic t_sticky();
        ev_queue_end = 1; step(); ev_queue_end = 0;
        check("R2 set bit1", {31'b0, flags[1]}, 1);
        step(); step();
        check("R2 held bit1", {31'b0, flags[1]}, 1);
        clear(7'b000_0001);
        check("R2 write0 keeps bit1", {31'b0, flags[1]}, 1);
        clear(7'b000_0010);
        check("R2 clear bit1", {31'b0, flags[1]}, 0);
        ev_tx_underflow = 1; step(); ev_tx_underflow = 0;
        check("R2 set bit2", {25'b0, flags}, 7'h04);
        clear(7'h04);
    endtask

    task automatic t_collision();
        ev_xfer_done = 1; step(); ev_xfer_done = 0;
        ev_xfer_done = 1; clr_we = 1; clr_mask = 7'h01; step();
        ev_xfer_done = 0; clr_we = 0; clr_mask = 0;
        check("R3 event beats clear", {31'b0, flags[0]}, 1);
        clear(7'h01);
        check("R3 later clear", {31'b0, flags[0]}, 0);
    endtask

    task automatic t_levels();
        tx_full = 0; rx_empty = 0; shift_busy = 1;
        check("R4 delay", {29'b0, flags[6:4]}, 0);
        step();
        check("R4 levels set", {29'b0, flags[6:4]}, 3'b111);
        clear(7'h70);
        check("R4 clear ignored", {29'b0, flags[6:4]}, 3'b111);
        tx_full = 1; rx_empty = 1; shift_busy = 0; step();
        check("R4 levels drop", {29'b0, flags[6:4]}, 0);
    endtask

    task automatic t_ovf_drop();
        rx_full = 1; cfg_rx_overwrite = 0; rx_word_in = 1; #1;
        check("R5 no push", {30'b0, rx_push, rx_replace}, 0);
        clr_we = 1; clr_mask = 7'h08;
        step(); rx_word_in = 0; clr_we = 0; clr_mask = 0;
        check("R5 ovf flag", {31'b0, flags[3]}, 1);
        clear(7'h08);
        check("R5 ovf cleared", {31'b0, flags[3]}, 0);
    endtask

    task automatic t_ovf_keep();
        cfg_rx_overwrite = 1; rx_word_in = 1; #1;
        check("R6 replace", {30'b0, rx_push, rx_replace}, 2'b11);
        step(); rx_word_in = 0;
        check("R6 ovf flag", {31'b0, flags[3]}, 1);
        clear(7'h08);
        rx_full = 0; rx_word_in = 1; #1;
        check("R6 normal push", {30'b0, rx_push, rx_replace}, 2'b10);
        step(); rx_word_in = 0;
        check("R6 no ovf", {31'b0, flags[3]}, 0);
        cfg_rx_overwrite = 0;
    endtask

    task automatic t_irq();
        cfg_en = 6'b000001;
        ev_queue_end = 1; step(); ev_queue_end = 0;
        check("R7 disabled flag", {31'b0, irq}, 0);
        ev_xfer_done = 1; step(); ev_xfer_done = 0;
        check("R7 enabled flag", {31'b0, irq}, 1);
        clear(7'h03);
        check("R7 irq drops", {31'b0, irq}, 0);
    endtask

    task automatic t_route();
        cfg_en = 6'b110000; cfg_dma_sel = 2'b01;
        tx_full = 0; rx_empty = 0; step();
        check("R8 tx dma", {30'b0, tx_dma_req, rx_dma_req}, 2'b10);
        check("R8 drain to irq", {31'b0, irq}, 1);
        cfg_dma_sel = 2'b11; step();
        check("R8 both dma", {30'b0, tx_dma_req, rx_dma_req}, 2'b11);
        check("R8 irq quiet", {31'b0, irq}, 0);
    endtask

    task automatic t_dma_drop();
        tx_full = 1; step();
        check("R9 tx drop", {30'b0, tx_dma_req, rx_dma_req}, 2'b01);
        rx_empty = 1; step();
        check("R9 rx drop", {30'b0, tx_dma_req, rx_dma_req}, 0);
        cfg_en = 0; cfg_dma_sel = 0;
    endtask

    initial begin
        step(); step();
        t_reset();
        rst_n = 1; step();
        t_reset();
        t_sticky();
        t_collision();
        t_levels();
        t_ovf_drop();
        t_ovf_keep();
        t_irq();
        t_route();
        t_dma_drop();
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_run++; n_fail++;
                $display("FAIL watchdog actual=hung expected=done");
            end
        join_any
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule